// File: doc/BRIEF.md
# Instruction Group Queue and Unit Dispatcher

This block sits between instruction fetch and the per-unit resource buffers of an execution core. Fetch delivers one group per cycle. A group holds four 32-bit instruction slots, a valid bit for each slot and a 2-bit activity number. Slots that carry no real instruction arrive as padding with their valid bit low. Accepted groups wait in a small in-order queue. The group at the head is sent to the resource buffers in one step, as a single indivisible dispatch.

Each valid slot is classified by the top two bits of its instruction word and mapped to one of five resource buffers:
- two integer buffers,
- one floating-point add buffer,
- one floating-point multiply buffer,
- one memory buffer.

The head group dispatches only when every buffer it needs reports a free rank. Every buffer that takes part in the dispatch sees all four instruction words. Its slot mask marks only the slots assigned to it. Integer work is steered to whichever integer buffer currently holds fewer occupied ranks.

The block tells fetch two things. It reports when any resource buffer is full, so that fetch can pause. It also reports when the group queue is full, and it drops any group that arrives with no room for it.

Top module: `quartet_dispatch`

## Requirements
- R1: After reset the queue is empty. No buffer push is asserted, `qFull` is low, and `grpAccept` is low while no group is offered.
- R2: An offered group whose four slot valid bits are all zero is not accepted (`grpAccept` low) and never causes a push.
- R3: The queue holds four groups. `qFull` is high exactly when four groups are held.
- R4: A group with at least one valid slot that is offered while the queue is full and no dispatch happens in that cycle is dropped. `grpDrop` is high for that cycle, and the queued contents are unchanged.
- R5: The head group dispatches in a cycle only if every buffer it needs has an occupied count below 4. Otherwise nothing is pushed and the head stays in place.
- R6: On dispatch, `rbPush[b]` is high exactly for the buffers with at least one assigned slot. Each such buffer's 4-bit mask in `rbSlotValid[b*4 +: 4]` has bit s set only for valid slots s assigned to it. Non-pushed buffers show a zero mask.
- R7: Unit class is taken from instruction bits [31:30]: 0 = integer (buffer 0 or 1), 1 = float add (buffer 2), 2 = float multiply (buffer 3), 3 = memory (buffer 4).
- R8: All integer slots of a group go to buffer 1 when its count is strictly below buffer 0's count, and to buffer 0 otherwise (ties go to buffer 0).
- R9: Groups dispatch in arrival order. `dispInstr` and `dispAct` carry the head group's words (slot s at bits [s*32 +: 32]) and activity number during a push.
- R10: `fetchHold` is high exactly when some buffer's occupied count equals 4.
- R11: When the queue is full and the head dispatches in the same cycle, a newly offered group with a valid slot is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grpValid | input | 1 | A group is offered this cycle |
| grpInstr | input | 128 | Four instruction words, slot s at [s*32 +: 32] |
| grpSlotValid | input | 4 | Per-slot valid bits of the offered group |
| grpAct | input | 2 | Activity number of the offered group |
| grpAccept | output | 1 | Offered group enters the queue at this edge |
| grpDrop | output | 1 | Offered group is discarded, queue full |
| qFull | output | 1 | Queue holds four groups |
| fetchHold | output | 1 | Some resource buffer is full |
| rbCount | input | 15 | Occupied ranks per buffer, 3 bits each, buffer b at [b*3 +: 3] |
| rbPush | output | 5 | Per-buffer dispatch strobe |
| rbSlotValid | output | 20 | Per-buffer slot masks, buffer b at [b*4 +: 4] |
| dispInstr | output | 128 | Head group instruction words |
| dispAct | output | 2 | Head group activity number |

## Verification
`grpAccept`, `grpDrop`, `qFull`, `fetchHold` and the dispatch outputs are combinational from the queue state and the current inputs. They are therefore due in the same cycle as the stimulus that causes them. A group accepted at one rising edge can appear on `rbPush` in the very next cycle, when it is at the head and has room. The bench drives inputs just after the falling edge and compares all outputs one nanosecond before the next rising edge, once they have settled. Its scoreboard then commits the expected pop and push at that edge, so every result is attributed to the cycle it belongs to.

// File: rtl/qdisp_pkg.sv
package qdisp_pkg;
  localparam int SLOTS  = 4;
  localparam int NUM_RB = 5;

  localparam int RB_INT0 = 0;
  localparam int RB_INT1 = 1;
  localparam int RB_FADD = 2;
  localparam int RB_FMUL = 3;
  localparam int RB_MEM  = 4;

  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FADD = 2'd1,
    CLS_FMUL = 2'd2,
    CLS_MEM  = 2'd3
  } unitCls_e;

  typedef struct packed {
    logic enq;
    logic deq;
  } qStrobe_t;
endpackage

// File: rtl/quartet_dispatch_store.sv
module quartet_dispatch_store
  import qdisp_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int ACT_W   = 2,
  parameter int Q_DEPTH = 4,
  localparam int GRP_W  = SLOTS * INSTR_W,
  localparam int QC_W   = $clog2(Q_DEPTH + 1),
  localparam int PTR_W  = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  qStrobe_t         strobe,
  input  logic [GRP_W-1:0] inInstr,
  input  logic [SLOTS-1:0] inValid,
  input  logic [ACT_W-1:0] inAct,
  output logic [GRP_W-1:0] headInstr,
  output logic [SLOTS-1:0] headValid,
  output logic [ACT_W-1:0] headAct,
  output logic [QC_W-1:0]  qCount
);
  logic [GRP_W-1:0] instrMem [Q_DEPTH];
  logic [SLOTS-1:0] validMem [Q_DEPTH];
  logic [ACT_W-1:0] actMem   [Q_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(Q_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.enq) begin
      instrMem[wrPtr] <= inInstr;
      validMem[wrPtr] <= inValid;
      actMem[wrPtr]   <= inAct;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (strobe.enq) wrPtr <= bump(wrPtr);
      if (strobe.deq) rdPtr <= bump(rdPtr);
      unique case ({strobe.enq, strobe.deq})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  assign headInstr = instrMem[rdPtr];
  assign headValid = (qCount == '0) ? '0 : validMem[rdPtr];
  assign headAct   = actMem[rdPtr];
endmodule

// File: rtl/quartet_dispatch_ctrl.sv
module quartet_dispatch_ctrl
  import qdisp_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int Q_DEPTH = 4,
  parameter int RANKS   = 4,
  localparam int GRP_W  = SLOTS * INSTR_W,
  localparam int QC_W   = $clog2(Q_DEPTH + 1),
  localparam int RC_W   = $clog2(RANKS + 1)
) (
  input  logic                    grpValid,
  input  logic [SLOTS-1:0]        grpSlotValid,
  input  logic [GRP_W-1:0]        headInstr,
  input  logic [SLOTS-1:0]        headValid,
  input  logic [QC_W-1:0]         qCount,
  input  logic [NUM_RB*RC_W-1:0]  rbCount,
  output qStrobe_t                strobe,
  output logic [NUM_RB-1:0]       rbPush,
  output logic [NUM_RB*SLOTS-1:0] rbSlotValid,
  output logic                    grpAccept,
  output logic                    grpDrop,
  output logic                    qFull,
  output logic                    fetchHold
);
  logic [NUM_RB-1:0]       hasRoom;
  logic [NUM_RB-1:0]       needed;
  logic [NUM_RB*SLOTS-1:0] slotMask;
  logic                    intPickHi;
  logic                    headGo;
  logic                    offerReal;

  for (genvar b = 0; b < NUM_RB; b++) begin : g_rb
    assign hasRoom[b] = rbCount[b*RC_W +: RC_W] < RC_W'(RANKS);
    assign needed[b]  = |slotMask[b*SLOTS +: SLOTS];
    assign rbPush[b]  = headGo & needed[b];
    assign rbSlotValid[b*SLOTS +: SLOTS] = headGo ? slotMask[b*SLOTS +: SLOTS] : '0;
  end

  // Integer steering: strictly fewer occupied ranks wins, ties stay low.
  assign intPickHi = rbCount[RB_INT1*RC_W +: RC_W] < rbCount[RB_INT0*RC_W +: RC_W];

  always_comb begin
    int tgt;
    slotMask = '0;
    for (int s = 0; s < SLOTS; s++) begin
      tgt = RB_INT0;
      unique case (unitCls_e'(headInstr[s*INSTR_W + INSTR_W - 1 -: 2]))
        CLS_INT:  tgt = intPickHi ? RB_INT1 : RB_INT0;
        CLS_FADD: tgt = RB_FADD;
        CLS_FMUL: tgt = RB_FMUL;
        CLS_MEM:  tgt = RB_MEM;
      endcase
      if (headValid[s]) slotMask[tgt*SLOTS + s] = 1'b1;
    end
  end

  assign qFull     = (qCount == QC_W'(Q_DEPTH));
  assign headGo    = (qCount != '0) && ((needed & ~hasRoom) == '0);
  assign offerReal = grpValid & (|grpSlotValid);
  assign grpAccept = offerReal & (~qFull | headGo);
  assign grpDrop   = offerReal & qFull & ~headGo;
  assign fetchHold = ~(&hasRoom);

  assign strobe.enq = grpAccept;
  assign strobe.deq = headGo;
endmodule

// File: rtl/quartet_dispatch.sv
module quartet_dispatch
  import qdisp_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int ACT_W   = 2,
  parameter int Q_DEPTH = 4,
  parameter int RANKS   = 4,
  localparam int GRP_W  = SLOTS * INSTR_W,
  localparam int QC_W   = $clog2(Q_DEPTH + 1),
  localparam int RC_W   = $clog2(RANKS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    grpValid,
  input  logic [GRP_W-1:0]        grpInstr,
  input  logic [SLOTS-1:0]        grpSlotValid,
  input  logic [ACT_W-1:0]        grpAct,
  output logic                    grpAccept,
  output logic                    grpDrop,
  output logic                    qFull,
  output logic                    fetchHold,
  input  logic [NUM_RB*RC_W-1:0]  rbCount,
  output logic [NUM_RB-1:0]       rbPush,
  output logic [NUM_RB*SLOTS-1:0] rbSlotValid,
  output logic [GRP_W-1:0]        dispInstr,
  output logic [ACT_W-1:0]        dispAct
);
  qStrobe_t         strobe;
  logic [SLOTS-1:0] headValid;
  logic [QC_W-1:0]  qCount;

  quartet_dispatch_store #(
    .INSTR_W(INSTR_W), .ACT_W(ACT_W), .Q_DEPTH(Q_DEPTH)
  ) store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inInstr(grpInstr), .inValid(grpSlotValid), .inAct(grpAct),
    .headInstr(dispInstr), .headValid(headValid), .headAct(dispAct),
    .qCount(qCount)
  );

  quartet_dispatch_ctrl #(
    .INSTR_W(INSTR_W), .Q_DEPTH(Q_DEPTH), .RANKS(RANKS)
  ) ctrl_i (
    .grpValid(grpValid), .grpSlotValid(grpSlotValid),
    .headInstr(dispInstr), .headValid(headValid), .qCount(qCount),
    .rbCount(rbCount), .strobe(strobe), .rbPush(rbPush),
    .rbSlotValid(rbSlotValid), .grpAccept(grpAccept), .grpDrop(grpDrop),
    .qFull(qFull), .fetchHold(fetchHold)
  );
endmodule

// File: rtl/quartet_dispatch_chk.sv
module quartet_dispatch_chk
  import qdisp_pkg::*;
#(
  parameter int RANKS = 4,
  localparam int RC_W = $clog2(RANKS + 1)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    grpValid,
  input logic [SLOTS-1:0]        grpSlotValid,
  input logic                    grpAccept,
  input logic                    grpDrop,
  input logic                    qFull,
  input logic [NUM_RB*RC_W-1:0]  rbCount,
  input logic [NUM_RB-1:0]       rbPush
);
  logic anyPush;
  assign anyPush = |rbPush;

  for (genvar b = 0; b < NUM_RB; b++) begin : g_room
    p_push_room_r5: assert property (@(posedge clk) disable iff (!rstN)
      rbPush[b] |-> (rbCount[b*RC_W +: RC_W] < RC_W'(RANKS)));
  end

  p_accept_real_r2: assert property (@(posedge clk) disable iff (!rstN)
    grpAccept |-> (|grpSlotValid));

  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (qFull && !anyPush) |=> qFull);

  p_drop_when_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    grpDrop |-> (qFull && !anyPush && !grpAccept));

  p_one_int_unit_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(rbPush[RB_INT0] && rbPush[RB_INT1]));

  p_accept_through_r11: assert property (@(posedge clk) disable iff (!rstN)
    (grpValid && (|grpSlotValid) && qFull && anyPush) |-> grpAccept);
endmodule

bind quartet_dispatch quartet_dispatch_chk #(.RANKS(RANKS)) chk_i (
  .clk(clk), .rstN(rstN), .grpValid(grpValid), .grpSlotValid(grpSlotValid),
  .grpAccept(grpAccept), .grpDrop(grpDrop), .qFull(qFull),
  .rbCount(rbCount), .rbPush(rbPush)
);

// File: tb/quartet_dispatch_tb_top.sv
module quartet_dispatch_tb_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic         grpValid;
  logic [127:0] grpInstr;
  logic [3:0]   grpSlotValid;
  logic [1:0]   grpAct;
  logic         grpAccept, grpDrop, qFull, fetchHold;
  logic [14:0]  rbCount;
  logic [4:0]   rbPush;
  logic [19:0]  rbSlotValid;
  logic [127:0] dispInstr;
  logic [1:0]   dispAct;

  always #2 clk = ~clk;

  quartet_dispatch dut_i (
    .clk(clk), .rstN(rstN), .grpValid(grpValid), .grpInstr(grpInstr),
    .grpSlotValid(grpSlotValid), .grpAct(grpAct), .grpAccept(grpAccept),
    .grpDrop(grpDrop), .qFull(qFull), .fetchHold(fetchHold),
    .rbCount(rbCount), .rbPush(rbPush), .rbSlotValid(rbSlotValid),
    .dispInstr(dispInstr), .dispAct(dispAct)
  );

  typedef struct {
    logic [127:0] ins;
    logic [3:0]   v;
    logic [1:0]   a;
  } grp_t;

  grp_t     sbQ[$];
  logic [2:0] cnt [5];
  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(input string tag, input logic [159:0] actual, input logic [159:0] expected);
    nChecks++;
    if (actual !== expected) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
    end
  endtask

  function automatic logic [31:0] mkI(input logic [1:0] cls, input int payload);
    return {cls, 30'(payload)};
  endfunction

  function automatic logic [19:0] expMasks(input grp_t g);
    logic [19:0] m = '0;
    for (int s = 0; s < 4; s++) begin
      if (g.v[s]) begin
        int b;
        case (g.ins[s*32+30 +: 2])
          2'd0: b = (cnt[1] < cnt[0]) ? 1 : 0;
          2'd1: b = 2;
          2'd2: b = 3;
          default: b = 4;
        endcase
        m[b*4 + s] = 1'b1;
      end
    end
    return m;
  endfunction

  // Driver + monitor for one cycle: offer inputs, compare, commit scoreboard.
  task automatic step(input logic v, input logic [127:0] ins, input logic [3:0] sv, input logic [1:0] act);
    logic [19:0] m;
    logic [4:0]  need;
    logic        go, real_, acc, hold;
    grpValid = v; grpInstr = ins; grpSlotValid = sv; grpAct = act;
    rbCount = {cnt[4], cnt[3], cnt[2], cnt[1], cnt[0]};
    #1;
    m = '0; need = '0; go = 1'b0;
    if (sbQ.size() > 0) begin
      m = expMasks(sbQ[0]);
      for (int b = 0; b < 5; b++) need[b] = |m[b*4 +: 4];
      go = 1'b1;
      for (int b = 0; b < 5; b++) if (need[b] && cnt[b] == 3'd4) go = 1'b0;
    end
    real_ = v && (|sv);
    acc   = real_ && (sbQ.size() < 4 || go);
    hold  = 1'b0;
    for (int b = 0; b < 5; b++) if (cnt[b] == 3'd4) hold = 1'b1;
    chk("R3 qFull", qFull, sbQ.size() == 4);
    chk("R2 R11 grpAccept", grpAccept, acc);
    chk("R4 grpDrop", grpDrop, real_ && sbQ.size() == 4 && !go);
    chk("R10 fetchHold", fetchHold, hold);
    chk("R5 R6 rbPush", rbPush, go ? need : 5'd0);
    chk("R6 R7 R8 rbSlotValid", rbSlotValid, go ? m : 20'd0);
    if (go) begin
      chk("R9 dispInstr", dispInstr, sbQ[0].ins);
      chk("R9 dispAct", dispAct, sbQ[0].a);
      void'(sbQ.pop_front());
    end
    if (acc) begin
      grp_t g;
      g.ins = ins; g.v = sv; g.a = act;
      sbQ.push_back(g);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, '0, 4'h0, 2'd0);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [127:0] gMix, gInt, gFadd, gPart;
    for (int b = 0; b < 5; b++) cnt[b] = 3'd0;
    rstN = 1'b0; grpValid = 1'b0; grpInstr = '0; grpSlotValid = '0; grpAct = '0;
    rbCount = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1 qFull", qFull, 1'b0);
    chk("R1 rbPush", rbPush, 5'd0);
    chk("R1 grpAccept", grpAccept, 1'b0);
    @(negedge clk);

    gMix  = {mkI(2'd3, 11), mkI(2'd2, 12), mkI(2'd1, 13), mkI(2'd0, 14)};
    gInt  = {mkI(2'd0, 21), mkI(2'd0, 22), mkI(2'd3, 23), mkI(2'd0, 24)};
    gFadd = {mkI(2'd1, 31), mkI(2'd0, 32), mkI(2'd1, 33), mkI(2'd2, 34)};
    gPart = {mkI(2'd0, 41), mkI(2'd2, 42), mkI(2'd1, 43), mkI(2'd3, 44)};

    // R7: one slot per class
    step(1'b1, gMix, 4'hF, 2'd1);
    idle();
    // R2: all-invalid group ignored, nothing dispatched afterwards
    step(1'b1, gInt, 4'h0, 2'd2);
    idle();
    idle();
    // R5/R3/R4: float-add buffer full blocks head, queue fills, overflow drops
    cnt[2] = 3'd4;
    step(1'b1, gFadd, 4'hF, 2'd0);
    step(1'b1, gInt, 4'hF, 2'd1);
    step(1'b1, gMix, 4'h5, 2'd2);
    step(1'b1, gPart, 4'h4, 2'd3);
    step(1'b1, gInt, 4'h3, 2'd0);
    step(1'b1, gMix, 4'hF, 2'd3);
    // R11: room frees while full, new offer accepted alongside dispatch
    cnt[2] = 3'd0;
    step(1'b1, gPart, 4'hB, 2'd2);
    // R8: steering under varied occupancy while draining
    cnt[0] = 3'd2; cnt[1] = 3'd1;
    idle();
    cnt[0] = 3'd1; cnt[1] = 3'd1;
    idle();
    cnt[0] = 3'd4; cnt[1] = 3'd0;
    idle();
    cnt[0] = 3'd4; cnt[1] = 3'd4;
    step(1'b1, gInt, 4'h9, 2'd1);
    idle();
    cnt[0] = 3'd3; cnt[1] = 3'd4;
    idle();
    cnt[0] = 3'd0; cnt[1] = 3'd0;
    for (int i = 0; i < 8; i++) idle();
    chk("R9 drained", sbQ.size(), 0);
    finishRun();
  end
endmodule